// File: doc/BRIEF.md
# Source-Address Learning, Aging and Lock Filter

This block sits beside the receive paths of a two-port bridge, one port facing a LAN and one facing a serial WAN link. For every received frame it is shown the source address, the destination address and the side the frame came from. One clock later it gives a forward/drop verdict. It keeps a small associative table of source addresses seen on the LAN side. A LAN frame whose destination is already in that table is local traffic and is not sent across the bridge. Entries that see no traffic for a number of aging ticks are removed. One control bit switches learning, aging and filtering on or off together.

A second, independent function limits which stations may use the bridge. When it is enabled, frames arriving on a selected side pass only if their source is one of a small locked set of 1 to 4 addresses. The set is filled with the first distinct sources seen on that side and is kept until reset. Frame storage and any large external address memory belong to the surrounding design. The table depth here is a parameter.

Top module: `mac_learn_filter`

## Requirements
- R1: After reset `dec_valid` and `dec_forward` are 0. A request sampled with `req_valid`=1 on a clock edge produces `dec_valid`=1 on the following cycle, together with its verdict on `dec_forward`. A cycle without a request gives `dec_valid`=0 and `dec_forward`=0.
- R2: With `cfg_learn_en`=1, a LAN-side frame (`req_port`=1) stores its source address in the table if it is not already there and a free entry exists. An address is never held twice.
- R3: With `cfg_learn_en`=1, a LAN-side frame whose destination is a valid table entry is dropped. A frame with an unknown destination is not dropped by filtering. WAN-side frames (`req_port`=0) are never dropped by filtering.
- R4: When every entry is valid, a new source address is not learned and the existing entries stay unchanged.
- R5: With `cfg_learn_en`=0 there is no learning, no aging and no filtering. The table contents are frozen and are used again once the bit returns to 1.
- R6: Each entry starts with a life of 3 aging ticks. Every `age_tick` cycle while `cfg_learn_en`=1 removes one unit, and the entry is removed on the third tick without a source hit. A source hit restores the full life, even when it comes in the same cycle as a tick.
- R7: With `cfg_lock_en`=0, locking has no effect on any frame.
- R8: With `cfg_lock_en`=1, size code `cfg_lock_size` values 0, 1, 2 and 3 admit 1, 2, 3 and 4 addresses. The first distinct sources seen on the locked side fill the set up to that limit and stay until reset. A frame from a source outside a full set is dropped.
- R9: `cfg_lock_side`=1 applies locking to LAN-side frames and `cfg_lock_side`=0 to WAN-side frames. Frames from the other side are not checked against the lock.
- R10: A LAN-side frame dropped by locking does not teach its source address to the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request for one received frame |
| req_port | input | 1 | Side the frame came from: 1 LAN, 0 WAN |
| req_src | input | 48 | Source address |
| req_dst | input | 48 | Destination address |
| cfg_learn_en | input | 1 | Enables learning, aging and filtering |
| cfg_lock_en | input | 1 | Enables source locking |
| cfg_lock_side | input | 1 | Locked side: 1 LAN, 0 WAN |
| cfg_lock_size | input | 2 | Lock set size code, N = code + 1 |
| age_tick | input | 1 | One aging step (a third of the aging interval) |
| dec_valid | output | 1 | Verdict strobe, one cycle after the request |
| dec_forward | output | 1 | 1 forward, 0 drop |

## Verification
A wrong table entry can only be seen through filtering. A lost or never-learned address shows as a LAN frame to that destination being forwarded instead of dropped, and a stale or duplicated address shows as a wrong drop. Either appears on the first frame aimed at that address. Age counter faults show up only at tick boundaries, so the bench probes destinations right before and after the third tick. It also sends a source hit in the same cycle as a tick. Lock set faults show up on the first source beyond the limit, or on a set member that is later refused. A shared reference model checks every verdict one cycle after its request, so a fault is caught within the cycle in which it first becomes visible.

// File: rtl/mlf_pkg.sv
package mlf_pkg;

    localparam int MAC_W = 48;

    typedef logic [MAC_W-1:0] mac_t;

    typedef enum logic {
        SIDE_WAN = 1'b0,
        SIDE_LAN = 1'b1
    } side_e;

    typedef struct packed {
        logic        learn_en;
        logic        lock_en;
        side_e       lock_side;
        logic [1:0]  lock_size;
    } cfg_t;

    typedef struct packed {
        side_e side;
        mac_t  src;
        mac_t  dst;
    } frame_t;

    // Size code 0..3 admits 1..4 locked addresses.
    function automatic logic [2:0] lock_limit(input logic [1:0] code);
        return {1'b0, code} + 3'd1;
    endfunction

endpackage

// File: rtl/mlf_learn_table.sv
module mlf_learn_table
    import mlf_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AGE_W = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic learn_req,
    input  logic age_tick,
    input  mac_t lk_src,
    input  mac_t lk_dst,
    output logic dst_hit,
    output logic full
);

    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AGE_W-1:0] AGE_FULL = {AGE_W{1'b1}};

    mac_t             mac_q [DEPTH];
    logic [AGE_W-1:0] age_q [DEPTH];
    logic [DEPTH-1:0] vld_q;

    logic [DEPTH-1:0] src_match;
    logic [DEPTH-1:0] dst_match;
    logic [IDX_W-1:0] free_idx;
    logic             src_known;
    logic             tick_en;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign src_match[g] = vld_q[g] && (mac_q[g] == lk_src);
        assign dst_match[g] = vld_q[g] && (mac_q[g] == lk_dst);
    end

    always_comb begin
        free_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!vld_q[i]) free_idx = IDX_W'(i);
        end
    end

    assign src_known = |src_match;
    assign dst_hit   = |dst_match;
    assign full      = &vld_q;
    assign tick_en   = en && age_tick;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                mac_q[i] <= '0;
                age_q[i] <= '0;
            end
        end else if (en) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (learn_req && src_match[i]) begin
                    age_q[i] <= AGE_FULL;
                end else if (learn_req && !src_known && !full &&
                             free_idx == IDX_W'(i)) begin
                    vld_q[i] <= 1'b1;
                    mac_q[i] <= lk_src;
                    age_q[i] <= AGE_FULL;
                end else if (tick_en && vld_q[i]) begin
                    if (age_q[i] == AGE_W'(1)) vld_q[i] <= 1'b0;
                    age_q[i] <= age_q[i] - 1'b1;
                end
            end
        end
    end

    // R2: an address is never present in two entries
    a_r2_single_copy: assert property (@(posedge clk) disable iff (rst)
        $onehot0(src_match));

    // R4: a full table only shrinks through aging
    a_r4_full_stable: assert property (@(posedge clk) disable iff (rst)
        full && !age_tick |=> vld_q == $past(vld_q));

    // R5: disabled table is frozen
    a_r5_frozen_off: assert property (@(posedge clk) disable iff (rst)
        !en |=> vld_q == $past(vld_q));

endmodule

// File: rtl/mlf_lock_set.sv
module mlf_lock_set
    import mlf_pkg::*;
#(
    parameter int SLOTS = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       check,
    input  mac_t       src,
    input  logic [1:0] size_code,
    output logic       pass
);

    localparam int CNT_W = $clog2(SLOTS + 1);

    mac_t             mac_q [SLOTS];
    logic [CNT_W-1:0] cnt_q;
    logic             hit;
    logic             room;
    int               lim;

    always_comb begin
        hit = 1'b0;
        for (int i = 0; i < SLOTS; i++) begin
            if (CNT_W'(i) < cnt_q && mac_q[i] == src) hit = 1'b1;
        end
        lim  = int'(lock_limit(size_code));
        if (lim > SLOTS) lim = SLOTS;
        room = int'(cnt_q) < lim;
        pass = hit || room;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            for (int i = 0; i < SLOTS; i++) mac_q[i] <= '0;
        end else if (check && !hit && room) begin
            for (int i = 0; i < SLOTS; i++) begin
                if (cnt_q == CNT_W'(i)) mac_q[i] <= src;
            end
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R8: locked members are kept until reset
    a_r8_never_shrinks: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> cnt_q >= $past(cnt_q));

    // R8: the set never exceeds its slots
    a_r8_bounded: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(SLOTS));

endmodule

// File: rtl/mac_learn_filter.sv
module mac_learn_filter
    import mlf_pkg::*;
#(
    parameter int TABLE_DEPTH = 16,
    parameter int LOCK_SLOTS  = 4,
    parameter int AGE_W       = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic        req_port,
    input  logic [47:0] req_src,
    input  logic [47:0] req_dst,
    input  logic        cfg_learn_en,
    input  logic        cfg_lock_en,
    input  logic        cfg_lock_side,
    input  logic [1:0]  cfg_lock_size,
    input  logic        age_tick,
    output logic        dec_valid,
    output logic        dec_forward
);

    cfg_t   cfg;
    frame_t frm;
    logic   lock_applies, lock_pass, lock_ok;
    logic   dst_hit, tbl_full, filt_drop, learn_req, fwd;

    assign cfg = '{learn_en:  cfg_learn_en,
                   lock_en:   cfg_lock_en,
                   lock_side: side_e'(cfg_lock_side),
                   lock_size: cfg_lock_size};
    assign frm = '{side: side_e'(req_port), src: req_src, dst: req_dst};

    assign lock_applies = cfg.lock_en && (frm.side == cfg.lock_side);
    assign lock_ok      = !lock_applies || lock_pass;
    assign filt_drop    = cfg.learn_en && (frm.side == SIDE_LAN) && dst_hit;
    assign learn_req    = req_valid && cfg.learn_en &&
                          (frm.side == SIDE_LAN) && lock_ok;
    assign fwd          = lock_ok && !filt_drop;

    mlf_learn_table #(.DEPTH(TABLE_DEPTH), .AGE_W(AGE_W)) u_table (
        .clk       (clk),
        .rst       (rst),
        .en        (cfg.learn_en),
        .learn_req (learn_req),
        .age_tick  (age_tick),
        .lk_src    (frm.src),
        .lk_dst    (frm.dst),
        .dst_hit   (dst_hit),
        .full      (tbl_full)
    );

    mlf_lock_set #(.SLOTS(LOCK_SLOTS)) u_lock (
        .clk       (clk),
        .rst       (rst),
        .check     (req_valid && lock_applies),
        .src       (frm.src),
        .size_code (cfg.lock_size),
        .pass      (lock_pass)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_valid   <= 1'b0;
            dec_forward <= 1'b0;
        end else begin
            dec_valid   <= req_valid;
            dec_forward <= req_valid && fwd;
        end
    end

    // R1: every request yields a verdict one cycle later
    a_r1_verdict_follows: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> dec_valid);

    // R1: no verdict without a request
    a_r1_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !dec_valid && !dec_forward);

    // R3, R7: WAN frames with locking off always cross the bridge
    a_r7_wan_unlocked_fwd: assert property (@(posedge clk) disable iff (rst)
        req_valid && !cfg_lock_en && !req_port |=> dec_forward);

    // R4: a full table stays usable, no learn is attempted into it
    a_r4_full_no_learn_slot: assert property (@(posedge clk) disable iff (rst)
        tbl_full && learn_req && !age_tick |=> tbl_full);

endmodule

// File: tb/mac_learn_filter_tb.sv
module mac_learn_filter_tb;

    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_port, age_tick;
    logic [47:0] req_src, req_dst;
    logic        cfg_learn_en, cfg_lock_en, cfg_lock_side;
    logic [1:0]  cfg_lock_size;
    logic        dec_valid, dec_forward;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    mac_learn_filter #(.TABLE_DEPTH(DEPTH), .LOCK_SLOTS(4), .AGE_W(2)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_port(req_port),
        .req_src(req_src), .req_dst(req_dst), .cfg_learn_en(cfg_learn_en),
        .cfg_lock_en(cfg_lock_en), .cfg_lock_side(cfg_lock_side),
        .cfg_lock_size(cfg_lock_size), .age_tick(age_tick),
        .dec_valid(dec_valid), .dec_forward(dec_forward)
    );

    // reference model
    logic [47:0] m_mac [DEPTH];
    bit          m_vld [DEPTH];
    int          m_age [DEPTH];
    logic [47:0] l_mac [4];
    int          l_cnt;

    function automatic logic [47:0] mac(input int k);
        return {32'hA0B0_C0D0, 16'(k)};
    endfunction

    task automatic check(input bit av, input bit af, input bit ev, input bit ef,
                         input string req);
        vectors++;
        if (av !== ev || af !== ef) begin
            miscompares++;
            $display("FAIL %s: valid/forward got %0b/%0b expected %0b/%0b",
                     req, av, af, ev, ef);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; req_valid = 1'b0; req_port = 1'b0; age_tick = 1'b0;
        req_src = '0; req_dst = '0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin m_vld[i] = 0; m_age[i] = 0; m_mac[i] = '0; end
        for (int i = 0; i < 4; i++) l_mac[i] = '0;
        l_cnt = 0;
    endtask

    // one cycle: drive at a falling edge, check at the next falling edge
    task automatic apply(input bit v, input bit port, input logic [47:0] src,
                         input logic [47:0] dst, input bit tick, input string req);
        bit lpass, lhit, dhit, shit, learn, ef;
        int cnt, free;
        lpass = 1; lhit = 0; dhit = 0; shit = 0; cnt = 0; free = -1;
        if (v && cfg_lock_en && port == cfg_lock_side) begin
            for (int i = 0; i < l_cnt; i++) if (l_mac[i] == src) lhit = 1;
            if (!lhit) begin
                if (l_cnt < int'(cfg_lock_size) + 1) begin
                    l_mac[l_cnt] = src; l_cnt++;
                end else lpass = 0;
            end
        end
        for (int i = 0; i < DEPTH; i++) begin
            if (m_vld[i] && m_mac[i] == dst) dhit = 1;
            if (m_vld[i] && m_mac[i] == src) shit = 1;
            if (m_vld[i]) cnt++;
            else if (free < 0) free = i;
        end
        ef = v && lpass && !(cfg_learn_en && port && dhit);
        learn = v && cfg_learn_en && port && lpass;
        if (cfg_learn_en) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (learn && m_vld[i] && m_mac[i] == src) m_age[i] = 3;
                else if (tick && m_vld[i]) begin
                    m_age[i]--;
                    if (m_age[i] == 0) m_vld[i] = 0;
                end
            end
            if (learn && !shit && cnt < DEPTH) begin
                m_vld[free] = 1; m_mac[free] = src; m_age[free] = 3;
            end
        end
        req_valid = v; req_port = port; req_src = src; req_dst = dst; age_tick = tick;
        @(negedge clk);
        check(dec_valid, dec_forward, v, ef, req);
        req_valid = 1'b0; age_tick = 1'b0;
    endtask

    task automatic tick_only(input string req);
        apply(0, 0, '0, '0, 1, req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: run did not finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        cfg_learn_en = 1'b1; cfg_lock_en = 1'b0; cfg_lock_side = 1'b1; cfg_lock_size = 2'd0;
        do_reset();
        // R1 reset state
        check(dec_valid, dec_forward, 0, 0, "R1 reset");

        // R2/R3 learning and filtering
        apply(1, 1, mac(1), mac(2), 0, "R3 unknown dst forwarded");
        apply(1, 1, mac(3), mac(1), 0, "R2 learned dst dropped");
        apply(1, 0, mac(9), mac(1), 0, "R3 WAN not filtered");
        apply(0, 1, mac(3), mac(1), 0, "R1 idle cycle");

        // R6 aging: mac(1) has had no source hit since learning
        tick_only("R6 tick1");
        tick_only("R6 tick2");
        apply(1, 1, mac(5), mac(1), 0, "R6 alive after two ticks");
        tick_only("R6 tick3");
        apply(1, 1, mac(5), mac(1), 0, "R6 removed after third tick");
        // refresh in same cycle as tick
        apply(1, 1, mac(6), mac(7), 0, "R2 learn 6");
        tick_only("R6 t");
        tick_only("R6 t");
        apply(1, 1, mac(6), mac(7), 1, "R6 hit with tick");
        tick_only("R6 t");
        tick_only("R6 t");
        apply(1, 1, mac(7), mac(6), 0, "R6 refreshed entry kept");

        // R4 full table
        do_reset();
        for (int k = 20; k < 20 + DEPTH; k++) apply(1, 1, mac(k), mac(99), 0, "R2 fill");
        apply(1, 1, mac(50), mac(99), 0, "R4 learn attempt when full");
        apply(1, 1, mac(21), mac(50), 0, "R4 new address not learned");
        apply(1, 1, mac(21), mac(20), 0, "R4 old entry kept");

        // R5 learning disabled
        cfg_learn_en = 1'b0;
        apply(1, 1, mac(22), mac(20), 0, "R5 no filtering");
        for (int k = 0; k < 4; k++) tick_only("R5 ticks ignored");
        cfg_learn_en = 1'b1;
        apply(1, 1, mac(22), mac(23), 0, "R5 table frozen not aged");
        do_reset();
        cfg_learn_en = 1'b0;
        apply(1, 1, mac(40), mac(99), 0, "R5 no learn");
        cfg_learn_en = 1'b1;
        apply(1, 1, mac(41), mac(40), 0, "R5 nothing learned while off");

        // R8/R9 lock on LAN, two addresses
        do_reset();
        cfg_learn_en = 1'b0; cfg_lock_en = 1'b1; cfg_lock_side = 1'b1; cfg_lock_size = 2'd1;
        apply(1, 1, mac(60), mac(99), 0, "R8 first lock");
        apply(1, 1, mac(61), mac(99), 0, "R8 second lock");
        apply(1, 1, mac(62), mac(99), 0, "R8 third refused");
        apply(1, 1, mac(60), mac(99), 0, "R8 member kept");
        apply(1, 0, mac(62), mac(99), 0, "R9 other side unchecked");
        cfg_lock_size = 2'd3;
        apply(1, 1, mac(62), mac(99), 0, "R8 size 4 admits third");
        apply(1, 1, mac(63), mac(99), 0, "R8 size 4 admits fourth");
        apply(1, 1, mac(64), mac(99), 0, "R8 fifth refused");

        // R9 lock on WAN side
        do_reset();
        cfg_lock_side = 1'b0; cfg_lock_size = 2'd0;
        apply(1, 0, mac(70), mac(99), 0, "R9 WAN lock first");
        apply(1, 0, mac(71), mac(99), 0, "R9 WAN lock refused");
        apply(1, 1, mac(71), mac(99), 0, "R9 LAN unchecked");

        // R10 locked-out source not learned, R7 lock off
        do_reset();
        cfg_learn_en = 1'b1; cfg_lock_side = 1'b1; cfg_lock_size = 2'd0;
        apply(1, 1, mac(80), mac(99), 0, "R10 member");
        apply(1, 1, mac(81), mac(99), 0, "R10 refused");
        apply(1, 1, mac(80), mac(81), 0, "R10 refused source not learned");
        apply(1, 1, mac(80), mac(80), 0, "R10 member learned");
        cfg_lock_en = 1'b0;
        apply(1, 1, mac(81), mac(99), 0, "R7 lock off");

        // constrained random mix
        do_reset();
        for (int n = 0; n < 4000; n++) begin
            if (n % 250 == 0) begin
                cfg_learn_en  = ($urandom % 4) != 0;
                cfg_lock_en   = $urandom % 2;
                cfg_lock_side = $urandom % 2;
                cfg_lock_size = 2'($urandom % 4);
            end
            apply(($urandom % 4) != 0, $urandom % 2, mac($urandom % 12),
                  mac($urandom % 12), ($urandom % 8) == 0, "R2 R3 R6 R8 random");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        void'($urandom(32'd12345));
    end

endmodule